// File: doc/BRIEF.md
# Wide-to-Narrow Request Splitter

This block joins a wide host port (128-bit data, 16-bit byte mask) to a narrow device port (32-bit data, 4-bit byte mask) on a request/response bus with valid/ready handshakes. Each accepted wide request is cut into 32-bit sub-requests, one for each 32-bit lane whose mask nibble has any bit set. Sub-requests are issued one at a time, lowest lane first. The block waits for each narrow response before it issues the next sub-request.

When every sub-request has been acknowledged, the block returns one wide response to the host. That response carries the host's source ID, an error flag that is the OR of all sub-response errors and, for a read, the returned 32-bit words placed back into their lanes. The host request channel stays closed while a transaction is in flight. The block runs in one clock domain and handles the write opcodes (full 0, partial 1) and the read opcode (4).

Top module: `wide2narrow_split`

## Requirements
- R1: Only lanes whose 4-bit mask nibble (host mask bits [4i+3:4i]) is non-zero produce a narrow request, and these are issued in ascending lane order.
- R2: The narrow request for lane i carries address base+4*i, where base is the host request address.
- R3: The narrow request for lane i carries host data bits [32i+31:32i], mask nibble i, size 2, the host opcode and the host source ID.
- R4: Exactly one host response is given, only after every issued sub-request has been acknowledged. It echoes the host source ID and carries opcode 1 for a read (opcode 4) and opcode 0 for a write.
- R5: The response error flag is the OR of the error flags of all narrow responses of the transaction, and it is 0 when none reports an error.
- R6: For a read, the data of each narrow response lands in its lane of the 128-bit response and unrequested lanes read zero. A write response carries all-zero data.
- R7: Host request ready is low from the cycle after a wide request is accepted until the cycle after its response has been handed off.
- R8: A request with an all-zero mask issues no narrow request and is answered with error 1 in the cycle after acceptance.
- R9: After reset, host request ready is 1 and both the narrow request valid and the host response valid are 0.
- R10: At most one narrow request is outstanding: narrow request valid is never high while the block waits for a narrow response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_a_valid | input | 1 | Host request valid |
| h_a_ready | output | 1 | Host request ready |
| h_a_opcode | input | 3 | Host opcode (0/1 write, 4 read) |
| h_a_address | input | AW (32) | Host request address |
| h_a_source | input | SRCW (8) | Host source ID |
| h_a_data | input | HOST_DW (128) | Host write data |
| h_a_mask | input | HOST_DW/8 (16) | Host byte mask |
| h_d_valid | output | 1 | Host response valid |
| h_d_ready | input | 1 | Host response ready |
| h_d_opcode | output | 3 | Response opcode (0 ack, 1 ack with data) |
| h_d_source | output | SRCW (8) | Echoed source ID |
| h_d_data | output | HOST_DW (128) | Merged read data |
| h_d_error | output | 1 | Merged error flag |
| n_a_valid | output | 1 | Narrow request valid |
| n_a_ready | input | 1 | Narrow request ready |
| n_a_opcode | output | 3 | Narrow opcode |
| n_a_size | output | 2 | Narrow size (log2 bytes) |
| n_a_address | output | AW (32) | Narrow address |
| n_a_source | output | SRCW (8) | Narrow source ID |
| n_a_data | output | DEV_DW (32) | Narrow write data |
| n_a_mask | output | DEV_DW/8 (4) | Narrow byte mask |
| n_d_valid | input | 1 | Narrow response valid |
| n_d_ready | output | 1 | Narrow response ready |
| n_d_data | input | DEV_DW (32) | Narrow read data |
| n_d_error | input | 1 | Narrow response error |

## Verification
On every cycle the assertions check four things. The host request channel stays closed while a transaction is in flight. No narrow request is raised while a narrow response is awaited. Narrow requests and host responses hold steady under backpressure. Every narrow request carries a non-empty mask and size 2. Which lanes are emitted, their order, addresses and data, the merged read data, the OR of errors and the immediate answer to an empty mask can only be shown by the bench scenarios. Those scenarios compare every narrow handshake and every host response with a queue-based expectation built from the mask pattern.

// File: rtl/w2n_pkg.sv
`timescale 1ns/1ps
package w2n_pkg;
  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;
  localparam logic [2:0] OP_ACK      = 3'd0;
  localparam logic [2:0] OP_ACK_DATA = 3'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } w2n_state_e;
endpackage

// File: rtl/w2n_lane_pick.sv
`timescale 1ns/1ps
// Lowest pending lane wins.
module w2n_lane_pick #(
  parameter int LANES = 4,
  parameter int LW    = 2
) (
  input  logic [LANES-1:0] pend,
  output logic             any,
  output logic [LW-1:0]    idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/w2n_resp_merge.sv
`timescale 1ns/1ps
// Per-lane response data register, cleared at the start of each transaction.
module w2n_resp_merge #(
  parameter int LANES  = 4,
  parameter int DEV_DW = 32,
  parameter int LW     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [LW-1:0]           wr_lane,
  input  logic [DEV_DW-1:0]       wr_data,
  output logic [LANES*DEV_DW-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [DEV_DW-1:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          lane_q <= '0;
        end else if (wr_en && (wr_lane == LW'(g))) begin
          lane_q <= wr_data;
        end
      end
      assign q[g*DEV_DW +: DEV_DW] = lane_q;
    end
  endgenerate
endmodule

// File: rtl/wide2narrow_split.sv
`timescale 1ns/1ps
module wide2narrow_split
  import w2n_pkg::*;
#(
  parameter int HOST_DW = 128,
  parameter int DEV_DW  = 32,
  parameter int AW      = 32,
  parameter int SRCW    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    h_a_valid,
  output logic                    h_a_ready,
  input  logic [2:0]              h_a_opcode,
  input  logic [AW-1:0]           h_a_address,
  input  logic [SRCW-1:0]         h_a_source,
  input  logic [HOST_DW-1:0]      h_a_data,
  input  logic [HOST_DW/8-1:0]    h_a_mask,
  output logic                    h_d_valid,
  input  logic                    h_d_ready,
  output logic [2:0]              h_d_opcode,
  output logic [SRCW-1:0]         h_d_source,
  output logic [HOST_DW-1:0]      h_d_data,
  output logic                    h_d_error,
  output logic                    n_a_valid,
  input  logic                    n_a_ready,
  output logic [2:0]              n_a_opcode,
  output logic [1:0]              n_a_size,
  output logic [AW-1:0]           n_a_address,
  output logic [SRCW-1:0]         n_a_source,
  output logic [DEV_DW-1:0]       n_a_data,
  output logic [DEV_DW/8-1:0]     n_a_mask,
  input  logic                    n_d_valid,
  output logic                    n_d_ready,
  input  logic [DEV_DW-1:0]       n_d_data,
  input  logic                    n_d_error
);
  localparam int LANES = HOST_DW / DEV_DW;
  localparam int HMW   = HOST_DW / 8;
  localparam int DMW   = DEV_DW / 8;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int OFFW  = $clog2(DMW);
  localparam logic [1:0] NSIZE = 2'(OFFW);

  w2n_state_e           st_q;
  logic [AW-1:0]        addr_q;
  logic [SRCW-1:0]      src_q;
  logic [2:0]           op_q;
  logic [HOST_DW-1:0]   wdat_q;
  logic [HMW-1:0]       mask_q;
  logic [LANES-1:0]     pend_q;
  logic [LW-1:0]        cur_q;
  logic                 err_q;

  logic [LANES-1:0]     lane_any;
  logic                 pick_any;
  logic [LW-1:0]        pick_idx;
  logic                 a_fire, na_fire, nd_fire, hd_fire;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_nib
      assign lane_any[g] = |h_a_mask[g*DMW +: DMW];
    end
  endgenerate

  w2n_lane_pick #(.LANES(LANES), .LW(LW)) u_pick (
    .pend (pend_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign a_fire  = h_a_valid && h_a_ready;
  assign na_fire = n_a_valid && n_a_ready;
  assign nd_fire = n_d_valid && n_d_ready;
  assign hd_fire = h_d_valid && h_d_ready;

  w2n_resp_merge #(.LANES(LANES), .DEV_DW(DEV_DW), .LW(LW)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .clr     (a_fire),
    .wr_en   (nd_fire && (op_q == OP_GET)),
    .wr_lane (cur_q),
    .wr_data (n_d_data),
    .q       (h_d_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      src_q  <= '0;
      op_q   <= OP_PUT_FULL;
      wdat_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
      cur_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (a_fire) begin
          addr_q <= h_a_address;
          src_q  <= h_a_source;
          op_q   <= h_a_opcode;
          wdat_q <= h_a_data;
          mask_q <= h_a_mask;
          pend_q <= lane_any;
          err_q  <= (lane_any == '0);
          st_q   <= (lane_any == '0) ? ST_RESP : ST_ISSUE;
        end
        ST_ISSUE: if (na_fire) begin
          pend_q[pick_idx] <= 1'b0;
          cur_q            <= pick_idx;
          st_q             <= ST_WAIT;
        end
        ST_WAIT: if (nd_fire) begin
          err_q <= err_q | n_d_error;
          st_q  <= (pend_q == '0) ? ST_RESP : ST_ISSUE;
        end
        ST_RESP: if (hd_fire) begin
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign h_a_ready   = (st_q == ST_IDLE);
  assign h_d_valid   = (st_q == ST_RESP);
  assign h_d_opcode  = (op_q == OP_GET) ? OP_ACK_DATA : OP_ACK;
  assign h_d_source  = src_q;
  assign h_d_error   = err_q;

  assign n_a_valid   = (st_q == ST_ISSUE) && pick_any;
  assign n_a_opcode  = op_q;
  assign n_a_size    = NSIZE;
  assign n_a_address = addr_q + (AW'(pick_idx) << OFFW);
  assign n_a_source  = src_q;
  assign n_a_data    = wdat_q[pick_idx*DEV_DW +: DEV_DW];
  assign n_a_mask    = mask_q[pick_idx*DMW +: DMW];
  assign n_d_ready   = (st_q == ST_WAIT);

  AST_READY_CLOSED: assert property (@(posedge clk) disable iff (rst)
    $past(h_a_valid && h_a_ready) |-> !h_a_ready);                  // R7
  AST_RESP_CLOSED: assert property (@(posedge clk) disable iff (rst)
    h_d_valid |-> (!h_a_ready && !n_a_valid));                       // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    n_d_ready |-> !n_a_valid);                                       // R10
  AST_NARROW_SHAPE: assert property (@(posedge clk) disable iff (rst)
    n_a_valid |-> (n_a_size == NSIZE && n_a_mask != '0));            // R3
  AST_NARROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (n_a_valid && !n_a_ready) |=> (n_a_valid && $stable(n_a_address) && $stable(n_a_data))); // R2
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (h_d_valid && !h_d_ready) |=> (h_d_valid && $stable(h_d_error) && $stable(h_d_data))); // R5
endmodule

// File: tb/sim_wide2narrow_split.sv
`timescale 1ns/1ps
module sim_wide2narrow_split;
  import w2n_pkg::*;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         h_a_valid = 1'b0;
  logic         h_a_ready;
  logic [2:0]   h_a_opcode = '0;
  logic [31:0]  h_a_address = '0;
  logic [7:0]   h_a_source = '0;
  logic [127:0] h_a_data = '0;
  logic [15:0]  h_a_mask = '0;
  logic         h_d_valid;
  logic         h_d_ready = 1'b0;
  logic [2:0]   h_d_opcode;
  logic [7:0]   h_d_source;
  logic [127:0] h_d_data;
  logic         h_d_error;
  logic         n_a_valid;
  logic         n_a_ready = 1'b0;
  logic [2:0]   n_a_opcode;
  logic [1:0]   n_a_size;
  logic [31:0]  n_a_address;
  logic [7:0]   n_a_source;
  logic [31:0]  n_a_data;
  logic [3:0]   n_a_mask;
  logic         n_d_valid = 1'b0;
  logic         n_d_ready;
  logic [31:0]  n_d_data = '0;
  logic         n_d_error = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  wide2narrow_split u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_pat(input int ln, input logic [7:0] src);
    return 32'hC0DE0000 ^ (32'(ln) * 32'h01010101) ^ {24'h0, src};
  endfunction

  task automatic run(input logic [2:0] op, input logic [31:0] addr, input logic [7:0] src,
                     input logic [127:0] wd, input logic [15:0] m, input logic [3:0] errl,
                     input int na_stall, input int hd_stall);
    logic [127:0] exp_d = '0;
    bit exp_e = 1'b0;
    int exp_n = 0;
    int lanes_q[$];
    int got = 0;
    bit done = 1'b0;
    bit rdy_bad = 1'b0;
    bit na_prev = 1'b0;
    bit nd_prev = 1'b0;
    int prev_lane = -1;
    int resp_lane = -1;
    int hd_seen = 0;
    int cyc = 0;
    for (int i = 0; i < 4; i++) begin
      if (m[4*i +: 4] != 4'h0) begin
        lanes_q.push_back(i);
        exp_n++;
        if (op == OP_GET) exp_d[32*i +: 32] = rd_pat(i, src);
        exp_e = exp_e | errl[i];
      end
    end
    if (exp_n == 0) exp_e = 1'b1;
    @(negedge clk);
    h_a_opcode = op; h_a_address = addr; h_a_source = src; h_a_data = wd; h_a_mask = m;
    h_a_valid = 1'b1;
    while (!h_a_ready) @(negedge clk);
    @(negedge clk);
    h_a_valid = 1'b0;
    while (!done && cyc < 200) begin
      if (h_a_ready) rdy_bad = 1'b1;
      if (exp_n == 0 && cyc == 0) chk(h_d_valid, "R8", "immediate response", 128'(h_d_valid), 128'd1);
      if (na_prev) resp_lane = prev_lane;
      if (nd_prev) n_d_valid = 1'b0;
      if (!n_d_valid && resp_lane >= 0) begin
        n_d_valid = 1'b1;
        n_d_data  = rd_pat(resp_lane, src);
        n_d_error = errl[resp_lane];
        resp_lane = -1;
      end
      n_a_ready = (na_stall == 0) || ((cyc % (na_stall + 1)) == na_stall);
      na_prev = 1'b0;
      if (n_a_valid && n_a_ready) begin
        if (lanes_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected narrow request", 128'(n_a_mask), 128'd0);
        end else begin
          int ln;
          ln = lanes_q.pop_front();
          chk(n_a_mask == m[4*ln +: 4], "R1", "lane order/mask", 128'(n_a_mask), 128'(m[4*ln +: 4]));
          chk(n_a_address == addr + 32'(4*ln), "R2", "narrow address", 128'(n_a_address), 128'(addr + 32'(4*ln)));
          chk(n_a_data == wd[32*ln +: 32], "R3", "narrow data", 128'(n_a_data), 128'(wd[32*ln +: 32]));
          chk({n_a_size, n_a_opcode, n_a_source} == {2'd2, op, src}, "R3", "size/opcode/source",
              128'({n_a_size, n_a_opcode, n_a_source}), 128'({2'd2, op, src}));
          prev_lane = ln;
          na_prev = 1'b1;
          got++;
        end
      end
      nd_prev = n_d_valid && n_d_ready;
      if (n_d_ready && n_a_valid) chk(1'b0, "R10", "request while waiting", 128'd1, 128'd0);
      h_d_ready = 1'b0;
      if (h_d_valid) begin
        if (hd_seen >= hd_stall) begin
          h_d_ready = 1'b1;
          chk(got == exp_n, "R4", "sub-requests before response", 128'(got), 128'(exp_n));
          chk(h_d_source == src, "R4", "echoed source", 128'(h_d_source), 128'(src));
          chk(h_d_opcode == ((op == OP_GET) ? OP_ACK_DATA : OP_ACK), "R4", "response opcode",
              128'(h_d_opcode), 128'((op == OP_GET) ? OP_ACK_DATA : OP_ACK));
          chk(h_d_error == exp_e, "R5", "merged error", 128'(h_d_error), 128'(exp_e));
          chk(h_d_data == exp_d, "R6", "merged data", h_d_data, exp_d);
          done = 1'b1;
        end
        hd_seen++;
      end
      @(negedge clk);
      cyc++;
    end
    h_d_ready = 1'b0;
    n_a_ready = 1'b0;
    n_d_valid = 1'b0;
    chk(done, "R4", "response received", 128'(done), 128'd1);
    chk(got == exp_n, "R1", "narrow request count", 128'(got), 128'(exp_n));
    chk(!rdy_bad, "R7", "ready low while busy", 128'(rdy_bad), 128'd0);
    chk(h_a_ready && !h_d_valid, "R7", "ready back after handoff", 128'(h_a_ready), 128'd1);
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(h_a_ready && !n_a_valid && !h_d_valid, "R9", "reset state",
        128'({h_a_ready, n_a_valid, h_d_valid}), 128'(3'b100));
    rst = 1'b0;
    @(negedge clk);
    chk(h_a_ready && !n_a_valid && !h_d_valid, "R9", "state after reset",
        128'({h_a_ready, n_a_valid, h_d_valid}), 128'(3'b100));
    run(OP_PUT_FULL, 32'h2000_0000, 8'h11, 128'h112233445566778899AABBCCDDEEFF00, 16'hFFFF, 4'h0, 0, 0);
    run(OP_PUT_PART, 32'h4001_0000, 8'h22, 128'h112233445566778899AABBCCDDEEFF00, 16'hF0F0, 4'h0, 1, 0);
    run(OP_GET,      32'h0000_0100, 8'h33, 128'h0, 16'hFFFF, 4'h0, 0, 2);
    run(OP_GET,      32'h1000_0040, 8'h44, 128'h0, 16'h0300, 4'h0, 2, 0);
    run(OP_PUT_PART, 32'h4000_0000, 8'h55, 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF, 16'h000F, 4'h1, 0, 0);
    run(OP_GET,      32'h2000_1000, 8'h66, 128'h0, 16'hFF0F, 4'h8, 1, 1);
    run(OP_PUT_FULL, 32'h2000_2000, 8'h77, 128'hFFFF, 16'h0000, 4'h0, 0, 0);
    run(OP_GET,      32'h2000_3000, 8'h88, 128'h0, 16'h8001, 4'h6, 0, 3);
    run(OP_GET,      32'h0000_0200, 8'h99, 128'h0, 16'h0000, 4'h0, 0, 1);
    run(OP_PUT_PART, 32'h0003_0010, 8'hAA, 128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0, 16'h4210, 4'h0, 3, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule